// File: doc/BRIEF.md
# Replayable Bank Request Queue

This block sits in front of one tag or data bank of a banked cache array. Several requesters offer requests into a shared queue. A fixed-priority arbiter admits at most one of them per cycle, and the queue presents one request at a time to the bank. Each admitted request is written into a storage slot once and is never moved. Three pointers walk over the slots: a write pointer, an issue pointer, and an oldest-retained pointer. A slot stays occupied until the bank reports that its access has finished, so any request that has been issued but not yet finished can be sent again.

The bank needs a multi-cycle access time. After each issue, a countdown counter is loaded from a programmable latency value, and the next issue waits until the counter reaches zero. A replay pulse moves the issue pointer back to the oldest request that has not finished, and every retained request is issued again in its original order. The bank clock enable is high only in a cycle where a request is actually being presented, so an idle bank, or a bank that is still counting, stays gated.

Top module: `bank_req_queue`

## Requirements
- R1: After reset, every source ready is high, no bank request is presented and the bank clock enable is low.
- R2: Source i sees ready high only when the queue is not full and no source with a lower index is requesting. When several sources request together, the lowest index is admitted first, and the others wait, holding their request, until they are admitted.
- R3: Requests are presented to the bank one per issue, in the order they were admitted, each carrying the payload that was admitted.
- R4: After an issue, no further issue occurs for L cycles, where L is the latency setting. When requests are waiting, consecutive issues are exactly L cycles apart.
- R5: A latency setting of 0 behaves as a latency of 1, which gives back-to-back issue.
- R6: A slot stays occupied after issue until a completion is signalled for it. With DEPTH slots occupied, every source ready is low. Each completion frees exactly one slot.
- R7: A completion signalled while no issued request is outstanding is ignored and frees nothing.
- R8: A replay pulse blocks issue in its own cycle and rewinds issue to the oldest request that has not finished. All retained requests are then issued again, in admission order.
- R9: The bank clock enable is high only in cycles where a request is presented to the bank. It is low while the queue holds nothing to issue and while the latency counter is running.
- R10: When every admitted request has already been issued, no request is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_valid | input | NUM_SRC | Request offered by each source |
| src_data | input | NUM_SRC*DW | Payload of each source, source i at bits i*DW upward |
| src_ready | output | NUM_SRC | Source i is admitted in a cycle where valid and ready are both high |
| lat_cfg | input | LAT_W | Bank latency in cycles (0 acts as 1); used when LAT_PROG is 1 |
| bank_done | input | 1 | Oldest outstanding access has finished |
| replay | input | 1 | Rewind issue to the oldest request that has not finished |
| bank_req_valid | output | 1 | A request is issued to the bank this cycle |
| bank_req_data | output | DW | Payload of the issued request |
| bank_clk_en | output | 1 | Clock enable for the bank |

## Verification
The bench builds the block with three sources, a depth of four, a 16-bit payload and a 4-bit programmable latency. The small depth lets four admissions reach the full condition, and that makes both the stray-completion case and the freeing of one slot visible at the ready outputs. The three sources give a two-deep chain of lower-index blocking. Latencies of 0 and 3 are used to measure exact issue spacing. Replay is exercised twice: once with every retained slot unfinished, and once after the oldest slot has finished.

// File: rtl/brq_pkg.sv
package brq_pkg;

  // A programmed latency of zero is served as one cycle.
  function automatic logic [15:0] eff_latency(input logic [15:0] cfg);
    return (cfg == 16'd0) ? 16'd1 : cfg;
  endfunction

  // Distance from the oldest-retained pointer to the write pointer, modulo 2**ptr_w.
  function automatic int unsigned ptr_span(input int unsigned wr, input int unsigned old,
                                           input int unsigned ptr_w);
    int unsigned mask;
    mask = (32'd1 << ptr_w) - 32'd1;
    return (wr - old) & mask;
  endfunction

endpackage

// File: rtl/brq_arb.sv
module brq_arb #(
  parameter int NUM_SRC = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] valid_i,
  input  logic               full_i,
  output logic [NUM_SRC-1:0] ready_o,
  output logic [NUM_SRC-1:0] grant_o
);
  logic [NUM_SRC-1:0] lower_busy;

  assign lower_busy[0] = 1'b0;
  for (genvar i = 1; i < NUM_SRC; i++) begin : g_chain
    assign lower_busy[i] = lower_busy[i-1] | valid_i[i-1];
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_rdy
    assign ready_o[i] = ~full_i & ~lower_busy[i];
  end

  assign grant_o = valid_i & ready_o;

  // R2: never more than one source admitted per cycle
  a_r2_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  // R6: no admission while full
  a_r6_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    full_i |-> (grant_o == '0));
endmodule

// File: rtl/brq_lat.sv
module brq_lat #(
  parameter int LAT_W       = 4,
  parameter bit LAT_PROG    = 1'b1,
  parameter int LAT_DEFAULT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LAT_W-1:0] cfg_i,
  input  logic             issue_i,
  output logic             idle_o
);
  logic [LAT_W-1:0] sel_cfg;
  logic [LAT_W-1:0] cnt_q;
  logic [15:0]      eff;

  if (LAT_PROG) begin : g_prog
    assign sel_cfg = cfg_i;
  end else begin : g_fixed
    assign sel_cfg = LAT_W'(LAT_DEFAULT);
  end

  assign eff    = brq_pkg::eff_latency(16'(sel_cfg));
  assign idle_o = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (issue_i) begin
      cnt_q <= LAT_W'(eff - 16'd1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R4: no issue while the countdown is running
  a_r4_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> !issue_i);

  // R4: the counter steps down by one per idle cycle
  a_r4_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt_q != '0) && !issue_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/brq_store.sv
module brq_store #(
  parameter int DEPTH = 4,
  parameter int DW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          issue_i,
  input  logic          done_i,
  input  logic          rewind_i,
  output logic [DW-1:0] head_data_o,
  output logic          pending_o,
  output logic          full_o
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int PTR_W = IDX_W + 1;

  logic [DW-1:0]    slots_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q, old_q;
  logic [PTR_W-1:0] occ;
  logic             outstanding;
  logic             done_ok;

  assign occ         = PTR_W'(brq_pkg::ptr_span(32'(wr_q), 32'(old_q), PTR_W));
  assign full_o      = (occ == PTR_W'(DEPTH));
  assign pending_o   = (rd_q != wr_q);
  assign outstanding = (old_q != rd_q);
  assign done_ok     = done_i & outstanding;
  assign head_data_o = slots_q[rd_q[IDX_W-1:0]];

  always_ff @(posedge clk) begin
    if (push_i) slots_q[wr_q[IDX_W-1:0]] <= push_data_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      old_q <= '0;
    end else begin
      if (push_i)  wr_q  <= wr_q + 1'b1;
      if (done_ok) old_q <= old_q + 1'b1;
      if (rewind_i)     rd_q <= done_ok ? old_q + 1'b1 : old_q;
      else if (issue_i) rd_q <= rd_q + 1'b1;
    end
  end

  // R6: retained count never exceeds the slot count
  a_r6_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= PTR_W'(DEPTH));

  // R6: a full queue admits nothing
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    full_o |-> !push_i);

  // R10: no issue when nothing is left to issue
  a_r10_no_issue_empty: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i |-> pending_o);

  // R7: a stray completion leaves the oldest pointer where it was
  a_r7_stray_done: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && !outstanding) |=> (old_q == $past(old_q)));

  // R8: replay rewinds issue to the oldest unfinished slot
  a_r8_rewind: assert property (@(posedge clk) disable iff (!rst_n)
    (rewind_i && !done_ok) |=> (rd_q == $past(old_q)));
endmodule

// File: rtl/bank_req_queue.sv
module bank_req_queue #(
  parameter int NUM_SRC     = 3,
  parameter int DEPTH       = 4,
  parameter int DW          = 16,
  parameter int LAT_W       = 4,
  parameter bit LAT_PROG    = 1'b1,
  parameter int LAT_DEFAULT = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_SRC-1:0]    src_valid,
  input  logic [NUM_SRC*DW-1:0] src_data,
  output logic [NUM_SRC-1:0]    src_ready,
  input  logic [LAT_W-1:0]      lat_cfg,
  input  logic                  bank_done,
  input  logic                  replay,
  output logic                  bank_req_valid,
  output logic [DW-1:0]         bank_req_data,
  output logic                  bank_clk_en
);
  logic [NUM_SRC-1:0] grant;
  logic [DW-1:0]      win_data [NUM_SRC];
  logic               push;
  logic               full;
  logic               pending;
  logic               lat_idle;
  logic               issue;

  brq_arb #(.NUM_SRC(NUM_SRC)) i_arb (
    .clk(clk), .rst_n(rst_n), .valid_i(src_valid), .full_i(full),
    .ready_o(src_ready), .grant_o(grant)
  );

  // One-hot payload select, folded as an OR chain
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_mux
    if (i == 0) begin : g_first
      assign win_data[i] = src_data[i*DW +: DW] & {DW{grant[i]}};
    end else begin : g_next
      assign win_data[i] = win_data[i-1] | (src_data[i*DW +: DW] & {DW{grant[i]}});
    end
  end

  assign push  = |grant;
  assign issue = pending & lat_idle & ~replay;

  brq_store #(.DEPTH(DEPTH), .DW(DW)) i_store (
    .clk(clk), .rst_n(rst_n), .push_i(push), .push_data_i(win_data[NUM_SRC-1]),
    .issue_i(issue), .done_i(bank_done), .rewind_i(replay),
    .head_data_o(bank_req_data), .pending_o(pending), .full_o(full)
  );

  brq_lat #(.LAT_W(LAT_W), .LAT_PROG(LAT_PROG), .LAT_DEFAULT(LAT_DEFAULT)) i_lat (
    .clk(clk), .rst_n(rst_n), .cfg_i(lat_cfg), .issue_i(issue), .idle_o(lat_idle)
  );

  assign bank_req_valid = issue;
  assign bank_clk_en    = issue;

  // R9: the bank clock stays gated with nothing pending
  a_r9_gate_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !pending |-> !bank_clk_en);

  // R9: the bank clock stays gated while the latency counter runs
  a_r9_gate_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !lat_idle |-> !bank_clk_en);

  // R8: nothing is issued in the replay cycle
  a_r8_replay_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    replay |-> !bank_req_valid);
endmodule

// File: tb/test_bank_req_queue.sv
`timescale 1ns/1ps
module test_bank_req_queue;
  localparam int NS = 3, DP = 4, DW = 16, LW = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NS-1:0]  src_valid = '0;
  logic [NS*DW-1:0] src_data = '0;
  logic [NS-1:0]  src_ready;
  logic [LW-1:0]  lat_cfg = 4'd1;
  logic           man_done = 1'b0, resp_done = 1'b0, bank_done;
  logic           replay = 1'b0;
  logic           bank_req_valid, bank_clk_en;
  logic [DW-1:0]  bank_req_data;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 1'b0, resp_en = 1'b0;
  logic [DW-1:0] exp_q[$];
  int iss_cyc[0:255];
  int n_iss = 0;

  assign bank_done = man_done | resp_done;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bank_req_queue #(.NUM_SRC(NS), .DEPTH(DP), .DW(DW), .LAT_W(LW)) i_bank_req_queue (
    .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_data(src_data),
    .src_ready(src_ready), .lat_cfg(lat_cfg), .bank_done(bank_done), .replay(replay),
    .bank_req_valid(bank_req_valid), .bank_req_data(bank_req_data), .bank_clk_en(bank_clk_en)
  );

  function automatic int tb_lat(input int c);
    return (c == 0) ? 1 : c;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  // Monitor: pops the scoreboard on every issue, watches the clock enable
  initial begin
    forever begin
      @(negedge clk); #1;
      if (rst_n) begin
        if (bank_clk_en) chk(bank_req_valid, "R9 clk_en without request", 1, 0);
        if (bank_req_valid) begin
          if (exp_q.size() == 0) chk(1'b0, "R3 unexpected issue", bank_req_data, 0);
          else begin
            logic [DW-1:0] e;
            e = exp_q.pop_front();
            chk(bank_req_data == e, "R3 issued payload", bank_req_data, e);
          end
          if (n_iss < 256) iss_cyc[n_iss] = cyc;
          n_iss++;
        end
      end
    end
  end

  // Bank model: fixed-latency responder
  initial begin
    int pend = 0;
    forever begin
      @(negedge clk); #1;
      resp_done = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) resp_done = 1'b1;
      end
      if (resp_en && bank_req_valid) pend = tb_lat(int'(lat_cfg));
    end
  end

  task automatic stream(input int s, input int n, input logic [DW-1:0] base);
    @(negedge clk);
    for (int k = 0; k < n; k++) begin
      src_valid[s] = 1'b1;
      src_data[s*DW +: DW] = base + DW'(k);
      #1;
      while (!src_ready[s]) begin @(negedge clk); #1; end
      exp_q.push_back(base + DW'(k));
      @(negedge clk);
    end
    src_valid[s] = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); man_done = 1'b1;
    @(negedge clk); man_done = 1'b0;
  endtask

  task automatic pulse_replay();
    @(negedge clk); replay = 1'b1;
    #1 chk(!bank_req_valid, "R8 no issue during replay", bank_req_valid, 0);
    @(negedge clk); replay = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic gaps(input int first, input int cnt, input int want, input string req);
    for (int k = first + 1; k < first + cnt; k++)
      chk(iss_cyc[k] - iss_cyc[k-1] == want, req, iss_cyc[k] - iss_cyc[k-1], want);
  endtask

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "watchdog expired", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int start;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(src_ready == '1, "R1 ready after reset", src_ready, 3'b111);
    chk(!bank_req_valid, "R1 no request after reset", bank_req_valid, 0);
    chk(!bank_clk_en, "R1 clock enable low after reset", bank_clk_en, 0);

    // R2 priority among simultaneous sources
    resp_en = 1'b1; lat_cfg = 4'd1;
    @(negedge clk);
    src_valid = 3'b111;
    src_data = {16'hA2, 16'hA1, 16'hA0};
    for (int k = 0; k < NS; k++) begin
      #1;
      chk(src_ready[k], "R2 lowest requester ready", src_ready[k], 1);
      for (int j = k + 1; j < NS; j++)
        chk(!src_ready[j], "R2 higher index held off", src_ready[j], 0);
      exp_q.push_back(16'hA0 + DW'(k));
      @(negedge clk);
      src_valid[k] = 1'b0;
    end
    settle(10);

    // R4 exact spacing with latency 3
    lat_cfg = 4'd3;
    start = n_iss;
    stream(0, 4, 16'h10);
    settle(20);
    chk(n_iss - start == 4, "R4 issue count", n_iss - start, 4);
    gaps(start, 4, 3, "R4 latency 3 spacing");

    // R5 latency 0 behaves as 1
    lat_cfg = 4'd0;
    start = n_iss;
    stream(1, 4, 16'h20);
    settle(12);
    chk(n_iss - start == 4, "R5 issue count", n_iss - start, 4);
    gaps(start, 4, 1, "R5 latency 0 back-to-back");

    // R7 stray completion, then R6 fill
    resp_en = 1'b0; lat_cfg = 4'd1;
    settle(4);
    pulse_done();
    stream(2, DP - 1, 16'h30);
    #1 chk(src_ready[0], "R7 stray completion freed nothing", src_ready[0], 1);
    stream(2, 1, 16'h33);
    #1 chk(src_ready == '0, "R6 full drops all ready", src_ready, 0);
    settle(8);

    // R8 replay with all slots unfinished
    for (int k = 0; k < DP; k++) exp_q.push_back(16'h30 + DW'(k));
    start = n_iss;
    pulse_replay();
    settle(8);
    chk(n_iss - start == DP, "R8 full replay count", n_iss - start, DP);
    #1 chk(src_ready == '0, "R6 slots retained after reissue", src_ready, 0);

    // R6 one completion frees one slot
    pulse_done();
    #1 chk(src_ready[0], "R6 completion frees a slot", src_ready[0], 1);

    // R8 replay resumes at the oldest unfinished request
    for (int k = 1; k < DP; k++) exp_q.push_back(16'h30 + DW'(k));
    start = n_iss;
    pulse_replay();
    settle(8);
    chk(n_iss - start == DP - 1, "R8 partial replay count", n_iss - start, DP - 1);

    for (int k = 1; k < DP; k++) pulse_done();
    @(negedge clk); #1;
    chk(src_ready == '1, "R6 all slots released", src_ready, 3'b111);
    for (int k = 0; k < 4; k++) begin
      chk(!bank_req_valid, "R10 no issue when drained", bank_req_valid, 0);
      chk(!bank_clk_en, "R9 clock gated when idle", bank_clk_en, 0);
      @(negedge clk); #1;
    end
    chk(exp_q.size() == 0, "R3 every expected issue seen", exp_q.size(), 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule